// File: doc/BRIEF.md
# Host Memory Address Decoder

This block sorts each host memory request into exactly one destination. The possible destinations are system DRAM, a 16 KB window of internal registers, a 4 KB egress-port register window, a flat configuration-access window, and the downstream I/O link, which takes everything else. It also reports three conditions:

- an access that a low-memory segment attribute refuses (access denied);
- an address beyond the addressable limit (unsupported);
- whether a configuration-window hit lands in the legacy or the extended part of a function's 4 KB configuration space.

Software-owned settings arrive as plain inputs: the top of low usable DRAM, three window bases with their enables, the configuration window size, and sixteen 2-bit attributes for the 0xC0000–0xFFFFF area. Nothing above the DRAM top is remapped.

Requests enter on a valid/ready stream, and results leave on a second valid/ready stream through a single register stage. The input is ready whenever the output register is empty or is being drained in the same cycle (`req_ready = !rsp_valid || rsp_ready`). While `rsp_valid` is high and `rsp_ready` is low, the result is held unchanged and no new request is taken. The decode path is purely combinational from the request and the settings into that register.

Top module: `host_addr_router`

## Requirements
- R1: After reset `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request accepted at a clock edge (`req_valid && req_ready`) appears on the output with `rsp_valid` = 1 after that edge. While `rsp_valid && !rsp_ready`, `req_ready` is 0 and every output field stays stable.
- R3: Parameter `LIMIT_4G` selects the limit. When it is 1, an address with any of bits [33:32] set is above the limit. When it is 0, an address with any of bits [33:31] set is above the limit. Such an access sets `rsp_unsup`, goes to the link and never to DRAM, whatever the windows say.
- R4: The configuration window hits when `cfg_en` = 1 and the address lies in the size-aligned block containing `cfg_base`. `cfg_size` 00 gives 64 MB, 01 gives 128 MB, and 10 or 11 gives 256 MB. Base bits below the selected size are ignored.
- R5: On a configuration-window hit, `rsp_cfg_ext` is 1 when address bits [11:0] are at least 0x100 (extended area) and 0 for 0x000–0x0FF (legacy area). It is 0 for every other destination.
- R6: The internal register window hits when `regs_en` = 1 and address bits [31:14] equal `regs_base`, which gives a 16 KB region.
- R7: The egress window hits when `ep_en` = 1 and address bits [31:12] equal `ep_base`, which gives a 4 KB region.
- R8: Priority, highest first: above-limit, configuration window, internal register window, egress window, low segments, DRAM below top, link.
- R9: Segment i (i = 0..15) covers 0xC0000 + i·0x4000 for 16 KB, and its attribute is `seg_attr[2i+1:2i]`. The codes are 00 disabled, 01 read-only, 10 write-only and 11 read/write. A permitted access goes to DRAM even at or above `dram_top`.
- R10: A read to a disabled or write-only segment, or a write to a disabled or read-only segment, goes to the link with `rsp_denied` = 1.
- R11: An address below 0xC0000 that no window hits goes to DRAM when it is below `dram_top`, with no attribute check.
- R12: An address at or above `dram_top` (and outside 0xC0000–0xFFFFF) that no window hits goes to the link with both flags 0.
- R13: `rsp_target` is one-hot. Bit 0 is DRAM, bit 1 the internal register window, bit 2 the egress window, bit 3 the configuration window and bit 4 the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_addr | input | 34 | Request physical address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_target | output | 5 | One-hot destination |
| rsp_denied | output | 1 | Segment attribute refused the access |
| rsp_unsup | output | 1 | Address above the addressable limit |
| rsp_cfg_ext | output | 1 | Configuration hit in the extended area |
| dram_top | input | 32 | Top of low usable DRAM (exclusive) |
| ep_en | input | 1 | Egress window enable |
| ep_base | input | 20 | Egress window base, address bits [31:12] |
| regs_en | input | 1 | Internal register window enable |
| regs_base | input | 18 | Internal register window base, bits [31:14] |
| cfg_en | input | 1 | Configuration window enable |
| cfg_base | input | 6 | Configuration window base, bits [31:26] |
| cfg_size | input | 2 | Configuration window size code |
| seg_attr | input | 32 | Sixteen 2-bit segment attributes |

## Verification
Every window is probed one below its base, at its base, at its last byte and one past its end. These probes separate a correct range compare from one that is off by one or uses the wrong size. The configuration window is swept through all four size codes and also given a misaligned base, which shows whether the low base bits are really ignored. Overlapping placements of windows, DRAM top and segments expose any error in the priority order. Reads and writes against each of the four attribute codes separate permitted from refused accesses. Seeded random addresses, biased toward window edges and mixed with random settings, are then compared against a bench model on both the 4 GB and the 2 GB variants, and a stalled consumer shows whether results are held.

// File: rtl/haddr_pkg.sv
package haddr_pkg;
  localparam int TGT_W  = 5;
  localparam int T_DRAM = 0;
  localparam int T_REGS = 1;
  localparam int T_EGR  = 2;
  localparam int T_CFG  = 3;
  localparam int T_LINK = 4;

  typedef enum logic [1:0] {
    ATTR_OFF = 2'b00,
    ATTR_RO  = 2'b01,
    ATTR_WO  = 2'b10,
    ATTR_RW  = 2'b11
  } seg_attr_e;

  typedef struct packed {
    logic [TGT_W-1:0] target;
    logic             denied;
    logic             unsup;
    logic             cfg_ext;
  } route_t;
endpackage

// File: rtl/addr_window.sv
module addr_window #(
  parameter int AW        = 32,
  parameter int SIZE_LOG2 = 12
) (
  input  logic                   en,
  input  logic [AW-1:SIZE_LOG2]  base,
  input  logic [AW-1:0]          addr,
  output logic                   hit
);
  logic [AW-1:0] unused_low;
  assign unused_low = {addr[AW-1:SIZE_LOG2], addr[SIZE_LOG2-1:0]};
  assign hit = en && (unused_low[AW-1:SIZE_LOG2] == base);
endmodule

// File: rtl/cfg_window.sv
module cfg_window #(
  parameter int AW       = 32,
  parameter int MIN_LOG2 = 26,
  parameter int NSIZES   = 3
) (
  input  logic                  en,
  input  logic [AW-1:MIN_LOG2]  base,
  input  logic [1:0]            size_sel,
  input  logic [AW-1:0]         addr,
  output logic                  hit,
  output logic                  ext
);
  localparam logic [1:0] LAST_SEL = 2'(NSIZES - 1);

  logic [NSIZES-1:0] size_hit;
  logic [1:0]        sel_c;

  for (genvar s = 0; s < NSIZES; s++) begin : g_size
    localparam int L = MIN_LOG2 + s;
    assign size_hit[s] = (addr[AW-1:L] == base[AW-1:L]);
  end

  assign sel_c = (size_sel > LAST_SEL) ? LAST_SEL : size_sel;
  assign hit   = en && size_hit[sel_c];
  assign ext   = |addr[11:8];
endmodule

// File: rtl/low_seg_gate.sv
module low_seg_gate
  import haddr_pkg::*;
#(
  parameter int AW       = 32,
  parameter int NSEG     = 16,
  parameter int SEG_LOG2 = 14,
  parameter int SEG_LO   = 32'h000C_0000
) (
  input  logic [AW-1:0]       addr,
  input  logic                is_write,
  input  logic [2*NSEG-1:0]   attr,
  output logic                in_region,
  output logic                allowed
);
  localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1;
  localparam logic [AW-1:0] LO = AW'(SEG_LO);
  localparam logic [AW-1:0] HI = AW'(SEG_LO + (NSEG << SEG_LOG2));

  seg_attr_e         fields [NSEG];
  logic [IDX_W-1:0]  idx;
  seg_attr_e         cur;

  for (genvar i = 0; i < NSEG; i++) begin : g_field
    assign fields[i] = seg_attr_e'(attr[2*i +: 2]);
  end

  assign in_region = (addr >= LO) && (addr < HI);
  assign idx       = IDX_W'((addr - LO) >> SEG_LOG2);
  assign cur       = fields[idx];

  always_comb begin
    unique case (cur)
      ATTR_RW:  allowed = 1'b1;
      ATTR_RO:  allowed = !is_write;
      ATTR_WO:  allowed = is_write;
      default:  allowed = 1'b0;
    endcase
  end
endmodule

// File: rtl/host_addr_router.sv
module host_addr_router
  import haddr_pkg::*;
#(
  parameter int ADDR_W   = 34,
  parameter bit LIMIT_4G = 1'b1,
  parameter int EP_LOG2  = 12,
  parameter int REG_LOG2 = 14,
  parameter int CFG_LOG2 = 26,
  parameter int NSEG     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  req_write,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [TGT_W-1:0]      rsp_target,
  output logic                  rsp_denied,
  output logic                  rsp_unsup,
  output logic                  rsp_cfg_ext,
  input  logic [31:0]           dram_top,
  input  logic                  ep_en,
  input  logic [31:EP_LOG2]     ep_base,
  input  logic                  regs_en,
  input  logic [31:REG_LOG2]    regs_base,
  input  logic                  cfg_en,
  input  logic [31:CFG_LOG2]    cfg_base,
  input  logic [1:0]            cfg_size,
  input  logic [2*NSEG-1:0]     seg_attr
);
  localparam int LIM_LOG2 = LIMIT_4G ? 32 : 31;

  logic [31:0] a32;
  logic        above;
  logic        cfg_hit, cfg_ext, regs_hit, ep_hit, seg_in, seg_ok;
  route_t      nxt, cur;

  assign a32   = req_addr[31:0];
  assign above = |req_addr[ADDR_W-1:LIM_LOG2];

  cfg_window #(.AW(32), .MIN_LOG2(CFG_LOG2), .NSIZES(3)) u_cfg (
    .en(cfg_en), .base(cfg_base), .size_sel(cfg_size), .addr(a32),
    .hit(cfg_hit), .ext(cfg_ext)
  );

  addr_window #(.AW(32), .SIZE_LOG2(REG_LOG2)) u_regs (
    .en(regs_en), .base(regs_base), .addr(a32), .hit(regs_hit)
  );

  addr_window #(.AW(32), .SIZE_LOG2(EP_LOG2)) u_ep (
    .en(ep_en), .base(ep_base), .addr(a32), .hit(ep_hit)
  );

  low_seg_gate #(.AW(32), .NSEG(NSEG)) u_seg (
    .addr(a32), .is_write(req_write), .attr(seg_attr),
    .in_region(seg_in), .allowed(seg_ok)
  );

  always_comb begin
    nxt = '0;
    if (above) begin
      nxt.target[T_LINK] = 1'b1;
      nxt.unsup          = 1'b1;
    end else if (cfg_hit) begin
      nxt.target[T_CFG]  = 1'b1;
      nxt.cfg_ext        = cfg_ext;
    end else if (regs_hit) begin
      nxt.target[T_REGS] = 1'b1;
    end else if (ep_hit) begin
      nxt.target[T_EGR]  = 1'b1;
    end else if (seg_in) begin
      if (seg_ok) begin
        nxt.target[T_DRAM] = 1'b1;
      end else begin
        nxt.target[T_LINK] = 1'b1;
        nxt.denied         = 1'b1;
      end
    end else if (a32 < dram_top) begin
      nxt.target[T_DRAM] = 1'b1;
    end else begin
      nxt.target[T_LINK] = 1'b1;
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      cur       <= '0;
    end else if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      cur       <= nxt;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_target  = cur.target;
  assign rsp_denied  = cur.denied;
  assign rsp_unsup   = cur.unsup;
  assign rsp_cfg_ext = cur.cfg_ext;
endmodule

// File: rtl/host_addr_router_chk.sv
module host_addr_router_chk
  import haddr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [TGT_W-1:0] rsp_target,
  input logic             rsp_denied,
  input logic             rsp_unsup,
  input logic             rsp_cfg_ext
);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_target)
      && $stable(rsp_denied) && $stable(rsp_unsup) && $stable(rsp_cfg_ext));

  p_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones(rsp_target) == 1);

  p_unsup_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_unsup |-> rsp_target[T_LINK] && !rsp_target[T_DRAM] && !rsp_denied);

  p_denied_link_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_denied |-> rsp_target[T_LINK]);

  p_ext_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_cfg_ext |-> rsp_target[T_CFG]);
endmodule

bind host_addr_router host_addr_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_target(rsp_target),
  .rsp_denied(rsp_denied), .rsp_unsup(rsp_unsup), .rsp_cfg_ext(rsp_cfg_ext)
);

// File: tb/sim_host_addr_router.sv
`timescale 1ns/1ps
module sim_host_addr_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [33:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_ready = 1'b1;
  logic [31:0] dram_top = 32'h4000_0000;
  logic        ep_en = 1'b1, regs_en = 1'b1, cfg_en = 1'b1;
  logic [31:0] ep_a   = 32'hFED1_9000;
  logic [31:0] regs_a = 32'hFED1_4000;
  logic [31:0] cfg_a  = 32'hE000_0000;
  logic [1:0]  cfg_size = 2'b10;
  logic [31:0] seg_attr = 32'hFFFF_FFFF;

  logic       req_ready, rsp_valid, rsp_denied, rsp_unsup, rsp_cfg_ext;
  logic [4:0] rsp_target;
  logic       r2_ready, r2_valid, r2_denied, r2_unsup, r2_ext;
  logic [4:0] r2_target;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  host_addr_router u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_target(rsp_target), .rsp_denied(rsp_denied),
    .rsp_unsup(rsp_unsup), .rsp_cfg_ext(rsp_cfg_ext), .dram_top(dram_top),
    .ep_en(ep_en), .ep_base(ep_a[31:12]), .regs_en(regs_en),
    .regs_base(regs_a[31:14]), .cfg_en(cfg_en), .cfg_base(cfg_a[31:26]),
    .cfg_size(cfg_size), .seg_attr(seg_attr)
  );

  host_addr_router #(.LIMIT_4G(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(r2_ready),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(r2_valid),
    .rsp_ready(rsp_ready), .rsp_target(r2_target), .rsp_denied(r2_denied),
    .rsp_unsup(r2_unsup), .rsp_cfg_ext(r2_ext), .dram_top(dram_top),
    .ep_en(ep_en), .ep_base(ep_a[31:12]), .regs_en(regs_en),
    .regs_base(regs_a[31:14]), .cfg_en(cfg_en), .cfg_base(cfg_a[31:26]),
    .cfg_size(cfg_size), .seg_attr(seg_attr)
  );

  // Packed result: {target[4:0], denied, unsup, cfg_ext}
  function automatic logic [7:0] model(input logic [33:0] a, input logic w, input logic full);
    logic [31:0] lo;
    longint sz, cbase, ad;
    logic [1:0] at;
    bit over, ok;
    lo = a[31:0];
    ad = longint'(lo);
    over = full ? (a[33:32] != 2'b00) : (a[33:31] != 3'b000);
    if (over) return {5'b10000, 1'b0, 1'b1, 1'b0};
    sz = 64'h400_0000 << ((cfg_size == 2'b11) ? 2 : cfg_size);
    cbase = longint'(cfg_a) & ~(sz - 1);
    if (cfg_en && ad >= cbase && ad < cbase + sz)
      return {5'b01000, 1'b0, 1'b0, (lo[11:0] >= 12'h100)};
    if (regs_en && ad >= longint'(regs_a) && ad < longint'(regs_a) + 16384)
      return {5'b00010, 3'b000};
    if (ep_en && ad >= longint'(ep_a) && ad < longint'(ep_a) + 4096)
      return {5'b00100, 3'b000};
    if (ad >= 64'hC0000 && ad < 64'h100000) begin
      at = seg_attr[((ad - 64'hC0000) / 16384) * 2 +: 2];
      ok = (at == 2'b11) || (at == 2'b01 && !w) || (at == 2'b10 && w);
      return ok ? {5'b00001, 3'b000} : {5'b10000, 1'b1, 1'b0, 1'b0};
    end
    if (lo < dram_top) return {5'b00001, 3'b000};
    return {5'b10000, 3'b000};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [33:0] a, input logic w, input string tag);
    logic [7:0] e0, e1;
    @(negedge clk);
    req_addr = a; req_write = w; req_valid = 1'b1;
    e0 = model(a, w, 1'b1);
    e1 = model(a, w, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " 4G addr"}, {23'd0, rsp_valid, rsp_target, rsp_denied, rsp_unsup, rsp_cfg_ext},
          {23'd0, 1'b1, e0});
    check({tag, " 2G addr"}, {23'd0, r2_valid, r2_target, r2_denied, r2_unsup, r2_ext},
          {23'd0, 1'b1, e1});
  endtask

  task automatic edges(input logic [31:0] b, input logic [31:0] sz, input string tag);
    xfer({2'b00, b - 32'd1}, 1'b0, tag);
    xfer({2'b00, b}, 1'b0, tag);
    xfer({2'b00, b + sz - 32'd1}, 1'b1, tag);
    xfer({2'b00, b + sz}, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    int unsigned pick;
    logic [33:0] ra;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: idle after reset
    check("R1 reset valid/ready", {30'd0, rsp_valid, req_ready}, {30'd0, 1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {30'd0, rsp_valid, req_ready}, {30'd0, 1'b0, 1'b1});

    // R6 internal register window, R7 egress window
    edges(regs_a, 32'h4000, "R6 regs window");
    edges(ep_a, 32'h1000, "R7 egress window");
    regs_en = 1'b0; xfer({2'b00, regs_a}, 1'b0, "R6 disabled"); regs_en = 1'b1;
    ep_en = 1'b0;   xfer({2'b00, ep_a}, 1'b0, "R7 disabled");   ep_en = 1'b1;

    // R4 size codes and alignment, R5 legacy/extended area
    for (int s = 0; s < 4; s++) begin
      cfg_size = 2'(s);
      edges(cfg_a, (s == 3) ? 32'h1000_0000 : (32'h400_0000 << s), "R4 cfg size");
    end
    cfg_a = 32'hE400_0000; cfg_size = 2'b10;
    edges(32'hE000_0000, 32'h1000_0000, "R4 misaligned base");
    cfg_a = 32'hE000_0000;
    xfer(34'h0_E000_00FF, 1'b0, "R5 legacy area");
    xfer(34'h0_E000_0100, 1'b0, "R5 extended area");
    xfer(34'h0_E00F_3FFF, 1'b1, "R5 extended top");
    cfg_en = 1'b0; xfer(34'h0_E000_0000, 1'b0, "R4 disabled"); cfg_en = 1'b1;

    // R3 limit
    xfer(34'h0_FFFF_FFFF, 1'b0, "R3 below 4G");
    xfer(34'h1_0000_0000, 1'b0, "R3 at 4G");
    xfer(34'h2_0000_1000, 1'b1, "R3 high bit");
    xfer(34'h0_7FFF_FFFF, 1'b0, "R3 below 2G");
    xfer(34'h0_8000_0000, 1'b0, "R3 at 2G");
    xfer(34'h1_0000_0000 | 34'(regs_a), 1'b0, "R3 alias over window");

    // R11 / R12 DRAM top
    xfer({2'b00, dram_top - 32'd1}, 1'b0, "R11 below top");
    xfer({2'b00, dram_top}, 1'b0, "R12 at top");
    seg_attr = 32'h0;
    xfer(34'h0_000B_FFFF, 1'b0, "R11 below segments no attr check");
    xfer(34'h0_0010_0000, 1'b1, "R11 above segments");

    // R9 / R10 segment attributes: field i = i mod 4
    for (int i = 0; i < 16; i++) seg_attr[2*i +: 2] = 2'(i % 4);
    for (int i = 0; i < 16; i++) begin
      xfer(34'(32'hC0000 + i * 32'h4000), 1'b0, "R9 R10 seg first read");
      xfer(34'(32'hC0000 + i * 32'h4000 + 32'h3FFF), 1'b1, "R9 R10 seg last write");
    end
    dram_top = 32'h0008_0000;
    xfer(34'h0_000C_C000, 1'b0, "R9 allowed above top");
    xfer(34'h0_000C_0000, 1'b0, "R10 disabled read");
    dram_top = 32'h4000_0000;

    // R8 priority with overlaps
    ep_a = 32'hFED1_5000;
    xfer({2'b00, ep_a}, 1'b0, "R8 regs over egress");
    ep_a = 32'h000C_4000;
    xfer(34'h0_000C_4000, 1'b0, "R8 egress over segment");
    xfer(34'h0_000C_5000, 1'b0, "R8 segment after egress");
    regs_a = 32'hE000_8000;
    xfer(34'h0_E000_8000, 1'b0, "R8 cfg over regs");
    dram_top = 32'hF000_0000;
    xfer(34'h0_E100_0000, 1'b0, "R8 cfg over dram");
    xfer(34'h0_F000_0000, 1'b0, "R12 link above top");
    regs_a = 32'hFED1_4000; ep_a = 32'hFED1_9000;

    // R2 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_addr = {2'b00, regs_a}; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    held = {rsp_target, rsp_denied, rsp_unsup, rsp_cfg_ext};
    check("R2 first result", {23'd0, rsp_valid, held}, {23'd0, 1'b1, model({2'b00, regs_a}, 1'b0, 1'b1)});
    req_addr = {2'b00, ep_a};
    repeat (2) begin
      @(negedge clk);
      check("R2 stalled hold", {22'd0, rsp_valid, req_ready, rsp_target, rsp_denied, rsp_unsup, rsp_cfg_ext},
            {22'd0, 1'b1, 1'b0, held});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 next after drain", {23'd0, rsp_valid, rsp_target, rsp_denied, rsp_unsup, rsp_cfg_ext},
          {23'd0, 1'b1, model({2'b00, ep_a}, 1'b0, 1'b1)});
    @(negedge clk);
    check("R2 empty after drain", {31'd0, rsp_valid}, 32'd0);

    // Random mix, R13 one-hot covered by full field compare
    for (int n = 0; n < 2500; n++) begin
      if (n % 100 == 0) begin
        seg_attr = $urandom;
        cfg_size = 2'($urandom_range(0, 3));
        dram_top = $urandom & 32'hFFF0_0000;
        ep_en = 1'($urandom); regs_en = 1'($urandom); cfg_en = 1'($urandom);
      end
      pick = $urandom_range(0, 5);
      case (pick)
        0: ra = {2'b00, regs_a} + 34'($urandom_range(0, 32'h8000)) - 34'h2000;
        1: ra = {2'b00, ep_a} + 34'($urandom_range(0, 32'h2000)) - 34'h800;
        2: ra = {2'b00, cfg_a} + 34'($urandom);
        3: ra = 34'($urandom_range(32'hB0000, 32'h10FFFF));
        4: ra = {2'b00, dram_top} + 34'($urandom_range(0, 8)) - 34'd4;
        default: ra = {2'($urandom), 32'($urandom)};
      endcase
      xfer(ra, 1'($urandom), "R13 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule